// File: doc/BRIEF.md
# Multi-Channel DMA Control Register Block

This block is the register slave of a multi-channel DMA engine. It holds the global configuration word, an error status word, an interrupt enable word, and the status words for the transmit and receive channels. Each channel has one bit in a channel-active word, one in an end-of-buffer word and one in a descriptor-error word. It also holds one descriptor pointer per transmit channel, one per receive channel, and one receive buffer size per receive channel. The numbers of transmit and receive channels are elaboration parameters, each from 1 to 32. The channel register windows grow and shrink with those parameters.

A control processor reaches the registers through a simple strobe bus. Each request carries a 10-bit register number and 32-bit data. Every request, mapped or not, is answered one cycle later with an acknowledge and registered read data. The DMA datapath reports events through pulse inputs. Those pulses set the status bits, and software clears them by writing 1s. Setting the top bit of a configuration write performs a soft reset of the global state and leaves the channel pointers and buffer sizes untouched. Four interrupt lines combine the enables with the status words.

Top module: `dma_chan_regfile`

## Requirements
- R1: After the synchronous reset, the configuration word (number 0x180) reads 0x0007C000. The error, enable, active, end-of-buffer and descriptor-error words read 0. `rsp_ack` and `irq_o` are 0.
- R2: A write to number 0x180 stores the written data ANDed with 0x00FFC087.
- R3: A write to 0x180 with bit 31 set first clears the error word, the enable word, both active words and the four channel status words. Event pulses that arrive in that same cycle are lost. Channel pointers and buffer sizes keep their values.
- R4: The error word (0x181, set by `err_evt`) and the channel status words are set by their event pulses. Channel i maps to bit i. The channel status words are transmit end-of-buffer 0x186, transmit descriptor-error 0x187, receive end-of-buffer 0x192 and receive descriptor-error 0x193. A write to any of these words clears exactly the bits written as 1. A pulse in the same cycle as the write takes precedence over the clear.
- R5: Transmit pointer i sits at 0x1A0+i for i below TX_CHANS, and receive pointer i sits at 0x1C0+i for i below RX_CHANS. Each pointer keeps all 32 written bits.
- R6: Receive buffer size i sits at 0x1E0+i for i below RX_CHANS. It keeps the low 8 bits of a write and reads back zero-extended.
- R7: A register number outside the mapped words and outside the configured windows reads as 0. A write to such a number changes no state.
- R8: Every request is acknowledged exactly one cycle after its strobe. Read data is valid with that acknowledge. `rsp_rdata` is 0 in every other cycle and with a write acknowledge. A read returns the state before that clock edge.
- R9: Each interrupt line is registered, one cycle after the state it reflects. `irq_o[0]` = enable bit 0 AND any transmit end-of-buffer bit. `irq_o[1]` = enable bit 1 AND any receive end-of-buffer bit. `irq_o[2]` = enable bit 2 AND any descriptor-error bit in either direction. `irq_o[3]` = enable bit 3 AND a non-zero error word.
- R10: The enable word (0x182) keeps bits 3:0. The transmit active word (0x184) keeps bits below TX_CHANS. The receive active word (0x190) keeps bits below RX_CHANS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | Request is a write when 1 |
| req_num | input | 10 | Register number |
| req_wdata | input | 32 | Write data |
| err_evt | input | 32 | Error event pulses, set the error word |
| tx_eob_evt | input | TX_CHANS | Transmit end-of-buffer pulses |
| tx_derr_evt | input | TX_CHANS | Transmit descriptor-error pulses |
| rx_eob_evt | input | RX_CHANS | Receive end-of-buffer pulses |
| rx_derr_evt | input | RX_CHANS | Receive descriptor-error pulses |
| rsp_ack | output | 1 | Acknowledge, one cycle after the strobe |
| rsp_rdata | output | 32 | Read data, valid with the acknowledge |
| irq_o | output | 4 | Interrupt request lines |

## Verification
The acknowledge and the read data of a request are due on the first clock edge after the strobe. A write or event becomes visible to a read issued in the next cycle. An interrupt line follows the state change by one more edge, so it follows an event pulse by two edges. The bench drives its inputs on the falling edge. A behavioural model steps on the same rising edge as the two design instances (4/2 and 32/32 channels). The acknowledge, read data and interrupt lines are compared on every falling edge, so each result is checked in exactly the cycle it is due. Directed reads that use literal expected values confirm the masks, the clear-on-write behaviour, the window limits and the pointers that survive a soft reset.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int unsigned NUM_W      = 10;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CHAN_IDX_W = 5;
  localparam int unsigned MAX_CHANS  = 1 << CHAN_IDX_W;
  localparam int unsigned IEN_W      = 4;
  localparam int unsigned IRQ_N      = 4;
  localparam int unsigned SIZE_W     = 8;
  localparam int unsigned SRST_BIT   = 31;

  localparam logic [NUM_W-1:0] RN_CFG     = 10'h180;
  localparam logic [NUM_W-1:0] RN_ERR     = 10'h181;
  localparam logic [NUM_W-1:0] RN_IEN     = 10'h182;
  localparam logic [NUM_W-1:0] RN_TX_ACT  = 10'h184;
  localparam logic [NUM_W-1:0] RN_TX_EOB  = 10'h186;
  localparam logic [NUM_W-1:0] RN_TX_DERR = 10'h187;
  localparam logic [NUM_W-1:0] RN_RX_ACT  = 10'h190;
  localparam logic [NUM_W-1:0] RN_RX_EOB  = 10'h192;
  localparam logic [NUM_W-1:0] RN_RX_DERR = 10'h193;
  localparam logic [NUM_W-1:0] RN_TX_PTR  = 10'h1A0;
  localparam logic [NUM_W-1:0] RN_RX_PTR  = 10'h1C0;
  localparam logic [NUM_W-1:0] RN_RX_SIZE = 10'h1E0;

  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007_C000;
  localparam logic [DATA_W-1:0] CFG_WMASK = 32'h00FF_C087;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CFG, SEL_ERR, SEL_IEN, SEL_TX_ACT, SEL_TX_EOB, SEL_TX_DERR,
    SEL_RX_ACT, SEL_RX_EOB, SEL_RX_DERR, SEL_TX_PTR, SEL_RX_PTR, SEL_RX_SIZE
  } reg_sel_e;

  typedef enum logic [1:0] {SRC_GLOB, SRC_TXP, SRC_RXP, SRC_SIZE} rd_src_e;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode import dma_rf_pkg::*; #(
  parameter int unsigned TX_CHANS = 4,
  parameter int unsigned RX_CHANS = 2
) (
  input  logic [NUM_W-1:0]      num,
  output reg_sel_e              sel,
  output logic [CHAN_IDX_W-1:0] chan
);
  localparam int unsigned WIN_W = NUM_W - CHAN_IDX_W;
  localparam logic [CHAN_IDX_W:0] TX_LIM = (CHAN_IDX_W+1)'(TX_CHANS);
  localparam logic [CHAN_IDX_W:0] RX_LIM = (CHAN_IDX_W+1)'(RX_CHANS);

  logic [WIN_W-1:0]      win;
  logic [CHAN_IDX_W:0]   off;

  assign win  = num[NUM_W-1:CHAN_IDX_W];
  assign chan = num[CHAN_IDX_W-1:0];
  assign off  = {1'b0, num[CHAN_IDX_W-1:0]};

  // R5/R6/R7: window hit only below the configured channel count
  always_comb begin
    sel = SEL_NONE;
    case (num)
      RN_CFG:     sel = SEL_CFG;
      RN_ERR:     sel = SEL_ERR;
      RN_IEN:     sel = SEL_IEN;
      RN_TX_ACT:  sel = SEL_TX_ACT;
      RN_TX_EOB:  sel = SEL_TX_EOB;
      RN_TX_DERR: sel = SEL_TX_DERR;
      RN_RX_ACT:  sel = SEL_RX_ACT;
      RN_RX_EOB:  sel = SEL_RX_EOB;
      RN_RX_DERR: sel = SEL_RX_DERR;
      default: begin
        if (win == RN_TX_PTR[NUM_W-1:CHAN_IDX_W] && off < TX_LIM)
          sel = SEL_TX_PTR;
        else if (win == RN_RX_PTR[NUM_W-1:CHAN_IDX_W] && off < RX_LIM)
          sel = SEL_RX_PTR;
        else if (win == RN_RX_SIZE[NUM_W-1:CHAN_IDX_W] && off < RX_LIM)
          sel = SEL_RX_SIZE;
      end
    endcase
  end
endmodule

// File: rtl/dma_rf_w1c.sv
module dma_rf_w1c #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_bits;
  assign clr_bits = clr_we ? clr_data : '0;

  // R4: set pulses win over a same-cycle clear; R3: soft clear drops pulses
  always_ff @(posedge clk) begin
    if (rst || soft_clr) q <= '0;
    else                 q <= (q & ~clr_bits) | set;
  end
endmodule

// File: rtl/dma_rf_chan_bank.sv
module dma_rf_chan_bank import dma_rf_pkg::*; #(
  parameter int unsigned WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [CHAN_IDX_W-1:0] addr,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      rdata
);
  localparam int unsigned SLOTS = 1 << CHAN_IDX_W;

  logic [WIDTH-1:0] mem [SLOTS];

  // single-port RAM with registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile import dma_rf_pkg::*; #(
  parameter int unsigned TX_CHANS = 4,
  parameter int unsigned RX_CHANS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [NUM_W-1:0]    req_num,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W-1:0]   err_evt,
  input  logic [TX_CHANS-1:0] tx_eob_evt,
  input  logic [TX_CHANS-1:0] tx_derr_evt,
  input  logic [RX_CHANS-1:0] rx_eob_evt,
  input  logic [RX_CHANS-1:0] rx_derr_evt,
  output logic                rsp_ack,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [IRQ_N-1:0]    irq_o
);
  if (TX_CHANS < 1 || TX_CHANS > MAX_CHANS) begin : g_bad_tx
    $error("TX_CHANS out of range");
  end
  if (RX_CHANS < 1 || RX_CHANS > MAX_CHANS) begin : g_bad_rx
    $error("RX_CHANS out of range");
  end

  reg_sel_e              sel;
  logic [CHAN_IDX_W-1:0] chan;
  logic                  wr, rd, soft_rst;

  logic [DATA_W-1:0]   cfg_q;
  logic [IEN_W-1:0]    ien_q;
  logic [TX_CHANS-1:0] tx_act_q;
  logic [RX_CHANS-1:0] rx_act_q;
  logic [DATA_W-1:0]   err_q;
  logic [TX_CHANS-1:0] tx_eob_q, tx_derr_q;
  logic [RX_CHANS-1:0] rx_eob_q, rx_derr_q;
  logic [DATA_W-1:0]   tx_ptr_rd, rx_ptr_rd;
  logic [SIZE_W-1:0]   size_rd;
  logic [DATA_W-1:0]   glob_rd, glob_q;
  rd_src_e             src_q;
  logic                ack_q;
  logic [IRQ_N-1:0]    irq_q;

  dma_rf_decode #(.TX_CHANS(TX_CHANS), .RX_CHANS(RX_CHANS)) u_dec (
    .num(req_num), .sel(sel), .chan(chan)
  );

  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign soft_rst = wr && (sel == SEL_CFG) && req_wdata[SRST_BIT];  // R3

  // R1/R2: configuration word with masked store
  always_ff @(posedge clk) begin
    if (rst)                          cfg_q <= CFG_RESET;
    else if (wr && sel == SEL_CFG)    cfg_q <= req_wdata & CFG_WMASK;
  end

  // R10: plain read/write words with kept-bit masks
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ien_q    <= '0;
      tx_act_q <= '0;
      rx_act_q <= '0;
    end else if (wr) begin
      if (sel == SEL_IEN)    ien_q    <= req_wdata[IEN_W-1:0];
      if (sel == SEL_TX_ACT) tx_act_q <= req_wdata[TX_CHANS-1:0];
      if (sel == SEL_RX_ACT) rx_act_q <= req_wdata[RX_CHANS-1:0];
    end
  end

  // R4: event status words
  dma_rf_w1c #(.W(DATA_W)) u_err (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .clr_we(wr && sel == SEL_ERR),
    .clr_data(req_wdata), .set(err_evt), .q(err_q)
  );
  dma_rf_w1c #(.W(TX_CHANS)) u_tx_eob (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .clr_we(wr && sel == SEL_TX_EOB),
    .clr_data(req_wdata[TX_CHANS-1:0]), .set(tx_eob_evt), .q(tx_eob_q)
  );
  dma_rf_w1c #(.W(TX_CHANS)) u_tx_derr (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .clr_we(wr && sel == SEL_TX_DERR),
    .clr_data(req_wdata[TX_CHANS-1:0]), .set(tx_derr_evt), .q(tx_derr_q)
  );
  dma_rf_w1c #(.W(RX_CHANS)) u_rx_eob (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .clr_we(wr && sel == SEL_RX_EOB),
    .clr_data(req_wdata[RX_CHANS-1:0]), .set(rx_eob_evt), .q(rx_eob_q)
  );
  dma_rf_w1c #(.W(RX_CHANS)) u_rx_derr (
    .clk(clk), .rst(rst), .soft_clr(soft_rst), .clr_we(wr && sel == SEL_RX_DERR),
    .clr_data(req_wdata[RX_CHANS-1:0]), .set(rx_derr_evt), .q(rx_derr_q)
  );

  // R5/R6: per-channel storage, untouched by soft reset
  dma_rf_chan_bank #(.WIDTH(DATA_W)) u_tx_ptr (
    .clk(clk), .we(wr && sel == SEL_TX_PTR), .addr(chan),
    .wdata(req_wdata), .rdata(tx_ptr_rd)
  );
  dma_rf_chan_bank #(.WIDTH(DATA_W)) u_rx_ptr (
    .clk(clk), .we(wr && sel == SEL_RX_PTR), .addr(chan),
    .wdata(req_wdata), .rdata(rx_ptr_rd)
  );
  dma_rf_chan_bank #(.WIDTH(SIZE_W)) u_rx_size (
    .clk(clk), .we(wr && sel == SEL_RX_SIZE), .addr(chan),
    .wdata(req_wdata[SIZE_W-1:0]), .rdata(size_rd)
  );

  // R7: global read mux, unmapped reads give zero
  always_comb begin
    case (sel)
      SEL_CFG:     glob_rd = cfg_q;
      SEL_ERR:     glob_rd = err_q;
      SEL_IEN:     glob_rd = DATA_W'(ien_q);
      SEL_TX_ACT:  glob_rd = DATA_W'(tx_act_q);
      SEL_TX_EOB:  glob_rd = DATA_W'(tx_eob_q);
      SEL_TX_DERR: glob_rd = DATA_W'(tx_derr_q);
      SEL_RX_ACT:  glob_rd = DATA_W'(rx_act_q);
      SEL_RX_EOB:  glob_rd = DATA_W'(rx_eob_q);
      SEL_RX_DERR: glob_rd = DATA_W'(rx_derr_q);
      default:     glob_rd = '0;
    endcase
  end

  // R8: response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      glob_q <= '0;
      src_q  <= SRC_GLOB;
    end else begin
      ack_q  <= req_valid;
      glob_q <= rd ? glob_rd : '0;
      src_q  <= SRC_GLOB;
      if (rd) begin
        case (sel)
          SEL_TX_PTR:  src_q <= SRC_TXP;
          SEL_RX_PTR:  src_q <= SRC_RXP;
          SEL_RX_SIZE: src_q <= SRC_SIZE;
          default:     src_q <= SRC_GLOB;
        endcase
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_TXP:  rsp_rdata = tx_ptr_rd;
      SRC_RXP:  rsp_rdata = rx_ptr_rd;
      SRC_SIZE: rsp_rdata = DATA_W'(size_rd);
      default:  rsp_rdata = glob_q;
    endcase
  end

  // R9: enable AND status, registered
  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else begin
      irq_q[0] <= ien_q[0] & (|tx_eob_q);
      irq_q[1] <= ien_q[1] & (|rx_eob_q);
      irq_q[2] <= ien_q[2] & ((|tx_derr_q) | (|rx_derr_q));
      irq_q[3] <= ien_q[3] & (|err_q);
    end
  end

  assign rsp_ack = ack_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk import dma_rf_pkg::*; #(
  parameter int unsigned RX_CHANS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic [NUM_W-1:0]    req_num,
  input logic [DATA_W-1:0]   req_wdata,
  input logic [RX_CHANS-1:0] rx_eob_evt,
  input logic                rsp_ack,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic [IRQ_N-1:0]    irq_o,
  input logic [DATA_W-1:0]   cfg_q,
  input logic [IEN_W-1:0]    ien_q,
  input logic [RX_CHANS-1:0] rx_eob_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_ack_next_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ack);
  assert_ack_only_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ack);
  assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_ack |-> rsp_rdata == '0);
  assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_num == RN_CFG)
      |=> cfg_q == ($past(req_wdata) & CFG_WMASK));
  assert_softrst_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_num == RN_CFG && req_wdata[SRST_BIT])
      |=> (ien_q == '0 && rx_eob_q == '0));
  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_num == RN_RX_EOB && rx_eob_evt == '0)
      |=> (rx_eob_q & $past(req_wdata[RX_CHANS-1:0])) == '0);
  assert_unmapped_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_num < RN_CFG)
      |=> ($stable(cfg_q) && $stable(ien_q)));

  for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(ien_q[k])) |-> !irq_o[k]);
  end
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.RX_CHANS(RX_CHANS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_num(req_num), .req_wdata(req_wdata), .rx_eob_evt(rx_eob_evt),
  .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .irq_o(irq_o),
  .cfg_q(cfg_q), .ien_q(ien_q), .rx_eob_q(rx_eob_q)
);

// File: tb/dma_chan_regfile_tb_top.sv
module rf_model #(
  parameter int TXN = 4,
  parameter int RXN = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [9:0]  req_num,
  input  logic [31:0] req_wdata,
  input  logic [31:0] err_evt,
  input  logic [31:0] tx_eob_evt,
  input  logic [31:0] tx_derr_evt,
  input  logic [31:0] rx_eob_evt,
  input  logic [31:0] rx_derr_evt,
  output logic        exp_ack,
  output logic [31:0] exp_rdata,
  output logic [3:0]  exp_irq,
  output logic        exp_known
);
  logic [31:0] cfg, err, ien, tact, ract, teob, tderr, reob, rderr;
  logic [31:0] tptr [32];
  logic [31:0] rptr [32];
  logic [31:0] rsz  [32];
  bit tptr_ok [32];
  bit rptr_ok [32];
  bit rsz_ok  [32];

  function automatic logic [31:0] chmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  logic [31:0] rv, wd;
  bit kn, srst;
  int n;

  always @(posedge clk) begin
    if (rst) begin
      cfg = 32'h0007_C000; err = 0; ien = 0; tact = 0; ract = 0;
      teob = 0; tderr = 0; reob = 0; rderr = 0;
      exp_ack <= 0; exp_rdata <= 0; exp_irq <= 0; exp_known <= 1;
    end else begin
      exp_irq <= {ien[3] && err != 0, ien[2] && (tderr | rderr) != 0,
                  ien[1] && reob != 0, ien[0] && teob != 0};
      exp_ack <= req_valid;
      rv = 0; kn = 1; n = int'(req_num); wd = req_wdata;
      if (req_valid && !req_write) begin
        case (n)
          'h180: rv = cfg;   'h181: rv = err;   'h182: rv = ien;
          'h184: rv = tact;  'h186: rv = teob;  'h187: rv = tderr;
          'h190: rv = ract;  'h192: rv = reob;  'h193: rv = rderr;
          default: begin
            if (n >= 'h1A0 && n < 'h1A0 + TXN) begin rv = tptr[n-'h1A0]; kn = tptr_ok[n-'h1A0]; end
            else if (n >= 'h1C0 && n < 'h1C0 + RXN) begin rv = rptr[n-'h1C0]; kn = rptr_ok[n-'h1C0]; end
            else if (n >= 'h1E0 && n < 'h1E0 + RXN) begin rv = rsz[n-'h1E0]; kn = rsz_ok[n-'h1E0]; end
          end
        endcase
      end
      exp_rdata <= rv; exp_known <= kn;
      srst = req_valid && req_write && n == 'h180 && wd[31];
      if (req_valid && req_write) begin
        case (n)
          'h180: cfg = wd & 32'h00FF_C087;
          'h181: err = err & ~wd;
          'h182: ien = wd & 32'hF;
          'h184: tact = wd & chmask(TXN);
          'h186: teob = teob & ~wd;
          'h187: tderr = tderr & ~wd;
          'h190: ract = wd & chmask(RXN);
          'h192: reob = reob & ~wd;
          'h193: rderr = rderr & ~wd;
          default: begin
            if (n >= 'h1A0 && n < 'h1A0 + TXN) begin tptr[n-'h1A0] = wd; tptr_ok[n-'h1A0] = 1; end
            if (n >= 'h1C0 && n < 'h1C0 + RXN) begin rptr[n-'h1C0] = wd; rptr_ok[n-'h1C0] = 1; end
            if (n >= 'h1E0 && n < 'h1E0 + RXN) begin rsz[n-'h1E0] = wd & 32'hFF; rsz_ok[n-'h1E0] = 1; end
          end
        endcase
      end
      if (srst) begin
        err = 0; ien = 0; tact = 0; ract = 0; teob = 0; tderr = 0; reob = 0; rderr = 0;
      end else begin
        err   = err | err_evt;
        teob  = teob | (tx_eob_evt & chmask(TXN));
        tderr = tderr | (tx_derr_evt & chmask(TXN));
        reob  = reob | (rx_eob_evt & chmask(RXN));
        rderr = rderr | (rx_derr_evt & chmask(RXN));
      end
    end
  end
endmodule

module dma_chan_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SM_TX = 4, SM_RX = 2, WD_TX = 32, WD_RX = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [9:0]  req_num = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] err_evt = '0, tx_eob_evt = '0, tx_derr_evt = '0, rx_eob_evt = '0, rx_derr_evt = '0;

  logic sm_ack, wd_ack, m_sm_ack, m_wd_ack, m_sm_kn, m_wd_kn;
  logic [31:0] sm_rdata, wd_rdata, m_sm_rdata, m_wd_rdata;
  logic [3:0] sm_irq, wd_irq, m_sm_irq, m_wd_irq;

  dma_chan_regfile #(.TX_CHANS(SM_TX), .RX_CHANS(SM_RX)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .err_evt(err_evt),
    .tx_eob_evt(tx_eob_evt[SM_TX-1:0]), .tx_derr_evt(tx_derr_evt[SM_TX-1:0]),
    .rx_eob_evt(rx_eob_evt[SM_RX-1:0]), .rx_derr_evt(rx_derr_evt[SM_RX-1:0]),
    .rsp_ack(sm_ack), .rsp_rdata(sm_rdata), .irq_o(sm_irq)
  );
  dma_chan_regfile #(.TX_CHANS(WD_TX), .RX_CHANS(WD_RX)) dut_wide_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .err_evt(err_evt),
    .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt),
    .rx_eob_evt(rx_eob_evt), .rx_derr_evt(rx_derr_evt),
    .rsp_ack(wd_ack), .rsp_rdata(wd_rdata), .irq_o(wd_irq)
  );

  rf_model #(.TXN(SM_TX), .RXN(SM_RX)) m_sm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .err_evt(err_evt),
    .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt), .rx_eob_evt(rx_eob_evt),
    .rx_derr_evt(rx_derr_evt), .exp_ack(m_sm_ack), .exp_rdata(m_sm_rdata),
    .exp_irq(m_sm_irq), .exp_known(m_sm_kn)
  );
  rf_model #(.TXN(WD_TX), .RXN(WD_RX)) m_wd (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .err_evt(err_evt),
    .tx_eob_evt(tx_eob_evt), .tx_derr_evt(tx_derr_evt), .rx_eob_evt(rx_eob_evt),
    .rx_derr_evt(rx_derr_evt), .exp_ack(m_wd_ack), .exp_rdata(m_wd_rdata),
    .exp_irq(m_wd_irq), .exp_known(m_wd_kn)
  );

  int checks = 0, fails = 0;
  bit done = 0, armed = 0;
  logic [9:0] last_num = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [9:0] n);
    if (n == 10'h180) return "R2";
    if (n == 10'h182 || n == 10'h184 || n == 10'h190) return "R10";
    if (n == 10'h181 || n == 10'h186 || n == 10'h187 || n == 10'h192 || n == 10'h193) return "R4";
    if (n >= 10'h1A0 && n < 10'h1E0) return "R5";
    if (n >= 10'h1E0) return "R6";
    return "R7";
  endfunction

  always @(posedge clk) last_num <= req_num;

  // per-cycle comparison against the model (R8 ack, R9 irq, read data)
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R8", "small ack", 32'(sm_ack), 32'(m_sm_ack));
      chk("R8", "wide ack", 32'(wd_ack), 32'(m_wd_ack));
      chk("R9", "small irq", 32'(sm_irq), 32'(m_sm_irq));
      chk("R9", "wide irq", 32'(wd_irq), 32'(m_wd_irq));
      if (m_sm_kn) chk(tag_of(last_num), "small rdata", sm_rdata, m_sm_rdata);
      if (m_wd_kn) chk(tag_of(last_num), "wide rdata", wd_rdata, m_wd_rdata);
    end
  end

  task automatic bus_wr(input logic [9:0] n, input logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_num = n; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [9:0] n, output logic [31:0] s, output logic [31:0] w);
    @(negedge clk); req_valid = 1; req_write = 0; req_num = n;
    @(negedge clk); req_valid = 0; s = sm_rdata; w = wd_rdata;
  endtask

  task automatic rd_chk(input logic [9:0] n, input logic [31:0] es, input logic [31:0] ew, input string tag);
    logic [31:0] s, w;
    bus_rd(n, s, w);
    chk(tag, $sformatf("small read 0x%03h", n), s, es);
    chk(tag, $sformatf("wide read 0x%03h", n), w, ew);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1;
      summary();
    end
  end

  initial begin
    @(posedge clk); armed = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset values
    rd_chk(10'h180, 32'h0007_C000, 32'h0007_C000, "R1");
    rd_chk(10'h181, 0, 0, "R1");
    rd_chk(10'h192, 0, 0, "R1");
    // fill every pointer and size slot, in and out of window
    for (int i = 0; i < 32; i++) begin
      bus_wr(10'h1A0 + 10'(i), 32'h1000_0000 + 32'(i));
      bus_wr(10'h1C0 + 10'(i), 32'h2000_0000 + 32'(i));
      bus_wr(10'h1E0 + 10'(i), 32'hABCD_0040 + 32'(i));
    end
    rd_chk(10'h1A1, 32'h1000_0001, 32'h1000_0001, "R5");
    rd_chk(10'h1C1, 32'h2000_0001, 32'h2000_0001, "R5");
    rd_chk(10'h1BF, 32'h0, 32'h1000_001F, "R7");
    rd_chk(10'h1C2, 32'h0, 32'h2000_0002, "R7");
    rd_chk(10'h1E1, 32'h41, 32'h41, "R6");
    rd_chk(10'h1E5, 32'h0, 32'h45, "R7");
    // R2: masked configuration store
    bus_wr(10'h180, 32'h7FFF_FFFF);
    rd_chk(10'h180, 32'h00FF_C087, 32'h00FF_C087, "R2");
    // R10: kept-bit masks
    bus_wr(10'h182, 32'hFFFF_FFFF);
    rd_chk(10'h182, 32'hF, 32'hF, "R10");
    bus_wr(10'h184, 32'hFFFF_FFFF);
    rd_chk(10'h184, 32'hF, 32'hFFFF_FFFF, "R10");
    bus_wr(10'h190, 32'hFFFF_FFFF);
    rd_chk(10'h190, 32'h3, 32'hFFFF_FFFF, "R10");
    // R4: event set, write-1 clear
    @(negedge clk); rx_eob_evt = 32'hFFFF_FFFF; err_evt = 32'h80;
    @(negedge clk); rx_eob_evt = 0; err_evt = 0;
    rd_chk(10'h192, 32'h3, 32'hFFFF_FFFF, "R4");
    chk("R9", "small irq rx eob", 32'(sm_irq[1]), 32'd1);
    bus_wr(10'h192, 32'h1);
    rd_chk(10'h192, 32'h2, 32'hFFFF_FFFE, "R4");
    rd_chk(10'h181, 32'h80, 32'h80, "R4");
    bus_wr(10'h181, 32'h80);
    rd_chk(10'h181, 32'h0, 32'h0, "R4");
    // R3: soft reset keeps pointers and sizes
    bus_wr(10'h180, 32'h8000_0001);
    rd_chk(10'h180, 32'h1, 32'h1, "R3");
    rd_chk(10'h182, 32'h0, 32'h0, "R3");
    rd_chk(10'h192, 32'h0, 32'h0, "R3");
    rd_chk(10'h1A1, 32'h1000_0001, 32'h1000_0001, "R3");
    rd_chk(10'h1E1, 32'h41, 32'h41, "R3");
    // R7: unmapped numbers
    bus_wr(10'h17F, 32'hFFFF_FFFF);
    rd_chk(10'h17F, 32'h0, 32'h0, "R7");
    rd_chk(10'h183, 32'h0, 32'h0, "R7");
    // mixed traffic compared cycle by cycle
    for (int it = 0; it < 4000; it++) begin
      logic [9:0] n;
      int pick;
      @(negedge clk);
      pick = int'($urandom % 6);
      case (pick)
        0, 5: begin
          case ($urandom % 11)
            0: n = 10'h180; 1: n = 10'h181; 2: n = 10'h182; 3: n = 10'h184;
            4: n = 10'h186; 5: n = 10'h187; 6: n = 10'h190; 7: n = 10'h192;
            8: n = 10'h193; 9: n = 10'h183; default: n = 10'h17F;
          endcase
        end
        1: n = 10'h1A0 + 10'($urandom % 32);
        2: n = 10'h1C0 + 10'($urandom % 32);
        3: n = 10'h1E0 + 10'($urandom % 32);
        default: n = 10'($urandom);
      endcase
      req_valid = ($urandom % 10) < 7;
      req_write = $urandom % 2;
      req_num   = n;
      req_wdata = $urandom;
      if (n == 10'h180 && ($urandom % 8) != 0) req_wdata[31] = 1'b0;
      err_evt     = (($urandom % 8) == 0) ? $urandom : 32'h0;
      tx_eob_evt  = (($urandom % 6) == 0) ? $urandom : 32'h0;
      tx_derr_evt = (($urandom % 8) == 0) ? $urandom : 32'h0;
      rx_eob_evt  = (($urandom % 6) == 0) ? $urandom : 32'h0;
      rx_derr_evt = (($urandom % 8) == 0) ? $urandom : 32'h0;
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
    err_evt = 0; tx_eob_evt = 0; tx_derr_evt = 0; rx_eob_evt = 0; rx_derr_evt = 0;
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule